// File: doc/BRIEF.md
# Floating-Point Exception Trap Decision Unit

This block sits after the floating-point execution units and consumes the six exception flags that one completed operation reports. On each accepted operation it merges flags into a sticky status register and decides whether the operation must raise an arithmetic trap. When it traps, it reports a summary code of the trapping conditions and a one-hot mask that identifies the destination register.

Two trap policies exist, selected per operation. The strict policy records every raised flag and traps on any flag that the per-instruction ignore mask does not cover; per-condition enables play no part. The software-completion policy applies the ignore mask first, records only the surviving flags, gates the summary with the enable mask, and marks the trap as a software-completion trap. Software may overwrite the sticky register through a dedicated write port. Trap vectoring and flag generation belong to other blocks.

Top module: `fp_trap_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `sticky_o`, `trap_o`, `trap_code_o` and `trap_regmask_o` are all zero.
- R2: Flag vector bit positions are: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact, bit 5 integer overflow. In strict mode (`swc_mode_i`=0) an accepted operation ORs every raised flag into `sticky_o`, whether ignored or not.
- R3: In strict mode a trap is raised when `op_flags_i & ~ignore_i` is nonzero; the summary reports exactly those flags, the software-completion bit is 0, and `enable_i` has no effect.
- R4: In software-completion mode (`swc_mode_i`=1) only `op_flags_i & ~ignore_i` is ORed into `sticky_o`; ignored flags leave it unchanged.
- R5: In software-completion mode a trap is raised when `op_flags_i & ~ignore_i` is nonzero; the summary reports those flags ANDed with `enable_i` and sets the software-completion bit, so if the enables remove every flag the summary is the software-completion bit alone.
- R6: An operation with an all-zero flag vector, or any cycle with `op_valid_i` low, changes nothing and raises no trap.
- R7: During a trap `trap_regmask_o` equals 1 shifted left by the destination register number; outside a trap it is zero.
- R8: Trap outputs appear in the cycle after the accepted operation and last one cycle; `trap_code_o` is zero whenever `trap_o` is low.
- R9: A software write loads `sticky_o` with `sw_wdata_i` in the next cycle; flags recorded by an operation in the same cycle are ORed on top of the written value.
- R10: Summary code bit positions are: bit 0 software completion, bit 1 invalid, bit 2 inexact, bit 3 underflow, bit 4 overflow, bit 5 divide-by-zero, bit 6 integer overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation result strobe |
| op_flags_i | input | 6 | Raised exception flags |
| ignore_i | input | 6 | Per-instruction ignore mask |
| enable_i | input | 6 | Per-condition trap enables |
| swc_mode_i | input | 1 | 1 selects the software-completion policy |
| dest_reg_i | input | 5 | Destination register number |
| sw_wr_i | input | 1 | Software write strobe for the sticky register |
| sw_wdata_i | input | 6 | Software write data |
| sticky_o | output | 6 | Sticky exception status |
| trap_o | output | 1 | One-cycle trap pulse |
| trap_code_o | output | 7 | Trap summary code |
| trap_regmask_o | output | 32 | One-hot destination register mask |

## Verification
A corrupted sticky bit shows on `sticky_o` the cycle after the operation that set it, and stays visible because nothing but reset or a software write clears it. A wrong policy decision appears on `trap_o` and `trap_code_o` exactly one cycle after the strobe, so each directed operation is checked at that single cycle and the pulse is checked to have dropped one cycle later. A bad register decode shows as a mask with the wrong bit or more than one bit set during the same pulse.

// File: rtl/fp_trap_pkg.sv
package fp_trap_pkg;

    localparam int FLAG_W = 6;
    localparam int CODE_W = 7;

    // Flag vector positions
    localparam int FL_INV = 0;
    localparam int FL_DZE = 1;
    localparam int FL_OVF = 2;
    localparam int FL_UNF = 3;
    localparam int FL_INE = 4;
    localparam int FL_IOV = 5;

    // Summary code positions
    localparam int SC_SWC = 0;
    localparam int SC_INV = 1;
    localparam int SC_INE = 2;
    localparam int SC_UNF = 3;
    localparam int SC_OVF = 4;
    localparam int SC_DZE = 5;
    localparam int SC_IOV = 6;

    typedef logic [FLAG_W-1:0] flags_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        POL_STRICT = 1'b0,
        POL_SWC    = 1'b1
    } policy_e;

    typedef struct packed {
        logic   fire;
        flags_t record;
        code_t  code;
    } verdict_t;

    function automatic code_t build_code(flags_t f, logic swc);
        code_t c;
        c         = '0;
        c[SC_SWC] = swc;
        c[SC_INV] = f[FL_INV];
        c[SC_INE] = f[FL_INE];
        c[SC_UNF] = f[FL_UNF];
        c[SC_OVF] = f[FL_OVF];
        c[SC_DZE] = f[FL_DZE];
        c[SC_IOV] = f[FL_IOV];
        return c;
    endfunction

endpackage

// File: rtl/fp_trap_policy.sv
module fp_trap_policy
    import fp_trap_pkg::*;
(
    input  flags_t   flags_i,
    input  flags_t   ignore_i,
    input  flags_t   enable_i,
    input  policy_e  policy_i,
    output verdict_t verdict_o
);

    flags_t surviving;

    always_comb begin
        surviving      = flags_i & ~ignore_i;
        verdict_o.fire = |surviving;
        if (policy_i == POL_SWC) begin
            verdict_o.record = surviving;
            verdict_o.code   = build_code(surviving & enable_i, 1'b1);
        end else begin
            verdict_o.record = flags_i;
            verdict_o.code   = build_code(surviving, 1'b0);
        end
    end

endmodule

// File: rtl/fp_sticky_reg.sv
module fp_sticky_reg
    import fp_trap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   acc_en_i,
    input  flags_t acc_bits_i,
    input  logic   wr_en_i,
    input  flags_t wr_data_i,
    output flags_t q_o
);

    flags_t base;
    flags_t add;

    always_comb begin
        base = wr_en_i  ? wr_data_i  : q_o;
        add  = acc_en_i ? acc_bits_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (wr_en_i || acc_en_i) begin
            q_o <= base | add;
        end
    end

endmodule

// File: rtl/fp_trap_report.sv
module fp_trap_report
    import fp_trap_pkg::*;
#(
    parameter int REG_COUNT = 32,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire_i,
    input  code_t                code_i,
    input  logic [IDX_W-1:0]     dest_i,
    output logic                 trap_o,
    output code_t                code_o,
    output logic [REG_COUNT-1:0] mask_o
);

    logic [REG_COUNT-1:0] mask_d;

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_dec
        assign mask_d[i] = fire_i && (dest_i == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_o <= 1'b0;
            code_o <= '0;
            mask_o <= '0;
        end else begin
            trap_o <= fire_i;
            code_o <= fire_i ? code_i : '0;
            mask_o <= mask_d;
        end
    end

endmodule

// File: rtl/fp_trap_unit.sv
module fp_trap_unit
    import fp_trap_pkg::*;
#(
    parameter int REG_COUNT = 32,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid_i,
    input  logic [5:0]           op_flags_i,
    input  logic [5:0]           ignore_i,
    input  logic [5:0]           enable_i,
    input  logic                 swc_mode_i,
    input  logic [IDX_W-1:0]     dest_reg_i,
    input  logic                 sw_wr_i,
    input  logic [5:0]           sw_wdata_i,
    output logic [5:0]           sticky_o,
    output logic                 trap_o,
    output logic [6:0]           trap_code_o,
    output logic [REG_COUNT-1:0] trap_regmask_o
);

    verdict_t verdict;
    policy_e  policy;
    logic     fire_gated;
    flags_t   sticky_q;
    code_t    code_q;

    assign policy     = swc_mode_i ? POL_SWC : POL_STRICT;
    assign fire_gated = op_valid_i && verdict.fire;

    fp_trap_policy u_policy (
        .flags_i   (op_flags_i),
        .ignore_i  (ignore_i),
        .enable_i  (enable_i),
        .policy_i  (policy),
        .verdict_o (verdict)
    );

    fp_sticky_reg u_sticky (
        .clk        (clk),
        .rst        (rst),
        .acc_en_i   (op_valid_i),
        .acc_bits_i (verdict.record),
        .wr_en_i    (sw_wr_i),
        .wr_data_i  (sw_wdata_i),
        .q_o        (sticky_q)
    );

    fp_trap_report #(.REG_COUNT(REG_COUNT)) u_report (
        .clk    (clk),
        .rst    (rst),
        .fire_i (fire_gated),
        .code_i (verdict.code),
        .dest_i (dest_reg_i),
        .trap_o (trap_o),
        .code_o (code_q),
        .mask_o (trap_regmask_o)
    );

    assign sticky_o    = sticky_q;
    assign trap_code_o = code_q;

endmodule

// File: rtl/fp_trap_unit_chk.sv
module fp_trap_unit_chk #(
    parameter int REG_COUNT = 32,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 op_valid_i,
    input logic [5:0]           op_flags_i,
    input logic [5:0]           ignore_i,
    input logic [5:0]           enable_i,
    input logic                 swc_mode_i,
    input logic [IDX_W-1:0]     dest_reg_i,
    input logic                 sw_wr_i,
    input logic [5:0]           sw_wdata_i,
    input logic [5:0]           sticky_o,
    input logic                 trap_o,
    input logic [6:0]           trap_code_o,
    input logic [REG_COUNT-1:0] trap_regmask_o
);

    // R6
    zero_flags_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && op_flags_i == 6'd0) |=> !trap_o);

    // R6
    idle_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid_i |=> !trap_o);

    // R7
    regmask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> $countones(trap_regmask_o) == 1);

    // R7
    regmask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_o |-> trap_regmask_o == '0);

    // R8
    code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_o |-> trap_code_o == 7'd0);

    // R3
    strict_no_swc_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && !swc_mode_i) |=> !trap_code_o[0]);

    // R5
    swc_bit_set_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && swc_mode_i && (op_flags_i & ~ignore_i) != 6'd0) |=> (trap_o && trap_code_o[0]));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid_i && !sw_wr_i) |=> $stable(sticky_o));

endmodule

bind fp_trap_unit fp_trap_unit_chk #(.REG_COUNT(REG_COUNT)) u_chk (.*);

// File: tb/fp_trap_unit_tb_top.sv
module fp_trap_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid_i;
    logic [5:0]  op_flags_i;
    logic [5:0]  ignore_i;
    logic [5:0]  enable_i;
    logic        swc_mode_i;
    logic [4:0]  dest_reg_i;
    logic        sw_wr_i;
    logic [5:0]  sw_wdata_i;
    logic [5:0]  sticky_o;
    logic        trap_o;
    logic [6:0]  trap_code_o;
    logic [31:0] trap_regmask_o;

    int vectors = 0;
    int fails   = 0;
    logic [5:0] exp_sticky;

    always #2 clk = ~clk;

    fp_trap_unit dut_i (.*);

    // R10 summary code layout
    function automatic logic [6:0] exp_code(logic [5:0] f, logic swc);
        return {f[5], f[1], f[2], f[3], f[4], f[0], swc};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply_op(input string req, input logic [5:0] f, input logic [5:0] ign,
                            input logic [5:0] en, input logic swc, input logic [4:0] d);
        logic [5:0] surv;
        logic       fire;
        logic [6:0] code;
        surv = f & ~ign;
        fire = |surv;
        if (swc) begin
            exp_sticky = exp_sticky | surv;
            code = exp_code(surv & en, 1'b1);
        end else begin
            exp_sticky = exp_sticky | f;
            code = exp_code(surv, 1'b0);
        end
        @(negedge clk);
        op_valid_i = 1'b1; op_flags_i = f; ignore_i = ign;
        enable_i = en; swc_mode_i = swc; dest_reg_i = d;
        @(negedge clk);
        op_valid_i = 1'b0;
        check(req, "trap", 32'(trap_o), 32'(fire));
        check(req, "code", 32'(trap_code_o), fire ? 32'(code) : 32'd0);
        check(req, "regmask", trap_regmask_o, fire ? (32'd1 << d) : 32'd0);
        check(req, "sticky", 32'(sticky_o), 32'(exp_sticky));
    endtask

    task automatic t_reset;
        check("R1", "sticky", 32'(sticky_o), 32'd0);
        check("R1", "trap", 32'(trap_o), 32'd0);
        check("R1", "code", 32'(trap_code_o), 32'd0);
        check("R1", "regmask", trap_regmask_o, 32'd0);
    endtask

    task automatic t_strict;
        // R2 ignored flags still recorded; R3 enables irrelevant
        apply_op("R2", 6'b010001, 6'b010000, 6'b000000, 1'b0, 5'd3);
        apply_op("R3", 6'b100110, 6'b000000, 6'b000000, 1'b0, 5'd17);
        apply_op("R3", 6'b001000, 6'b001000, 6'b111111, 1'b0, 5'd9);
    endtask

    task automatic t_pulse;
        // R8 pulse lasts one cycle
        apply_op("R8", 6'b000010, 6'b000000, 6'b000000, 1'b0, 5'd31);
        @(negedge clk);
        check("R8", "trap drop", 32'(trap_o), 32'd0);
        check("R8", "code drop", 32'(trap_code_o), 32'd0);
    endtask

    task automatic t_swc;
        // R4 ignored flags not recorded
        sw_write(6'd0, 1'b0);
        apply_op("R4", 6'b110000, 6'b100000, 6'b111111, 1'b1, 5'd0);
        // R5 partial enables
        apply_op("R5", 6'b001101, 6'b000000, 6'b000101, 1'b1, 5'd12);
        // R5 enables remove everything
        apply_op("R5", 6'b000010, 6'b000000, 6'b000000, 1'b1, 5'd7);
        // R4 all ignored: no trap, nothing recorded
        apply_op("R4", 6'b000001, 6'b000001, 6'b111111, 1'b1, 5'd5);
    endtask

    task automatic t_zero;
        // R6 zero flags
        apply_op("R6", 6'b000000, 6'b000000, 6'b111111, 1'b0, 5'd4);
        apply_op("R6", 6'b000000, 6'b000000, 6'b111111, 1'b1, 5'd4);
        // R6 strobe low with flags present
        @(negedge clk);
        op_flags_i = 6'b111111; ignore_i = 6'd0; op_valid_i = 1'b0;
        @(negedge clk);
        check("R6", "trap idle", 32'(trap_o), 32'd0);
        check("R6", "sticky idle", 32'(sticky_o), 32'(exp_sticky));
    endtask

    task automatic sw_write(input logic [5:0] data, input logic chk);
        @(negedge clk);
        sw_wr_i = 1'b1; sw_wdata_i = data;
        @(negedge clk);
        sw_wr_i = 1'b0;
        exp_sticky = data;
        if (chk) check("R9", "sticky write", 32'(sticky_o), 32'(data));
    endtask

    task automatic t_write;
        sw_write(6'b101010, 1'b1);
        // R9 same-cycle write and op
        @(negedge clk);
        sw_wr_i = 1'b1; sw_wdata_i = 6'b000001;
        op_valid_i = 1'b1; op_flags_i = 6'b010000; ignore_i = 6'd0;
        enable_i = 6'd0; swc_mode_i = 1'b0; dest_reg_i = 5'd1;
        @(negedge clk);
        sw_wr_i = 1'b0; op_valid_i = 1'b0;
        exp_sticky = 6'b010001;
        check("R9", "write merge", 32'(sticky_o), 32'(exp_sticky));
        check("R9", "trap with write", 32'(trap_o), 32'd1);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid_i = 1'b0; op_flags_i = '0; ignore_i = '0;
        enable_i = '0; swc_mode_i = 1'b0; dest_reg_i = '0;
        sw_wr_i = 1'b0; sw_wdata_i = '0; exp_sticky = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_strict();
        t_pulse();
        t_swc();
        t_zero();
        t_write();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule